// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one DMA channel. It moves data between a memory window and one peripheral register, one unit at a time. Each unit is a read on a single-beat bus master port followed by a write of the captured word. Software loads a memory start address, a memory end address and a device address, then picks the unit size, the direction and the address-increment options in a control word. After each unit, the memory start register moves up by the unit size. The transfer is over when start equals end, so the bytes still to move can always be read as end minus start.

Units can be paced in two ways. In the first, the peripheral raises a flow-control request and receives one acknowledge pulse per finished unit. In the second, flow control is switched off and a software go bit runs the whole window back to back. Three status bits report completion, a flow-control fault and a bus fault. Each status bit can raise the interrupt output through its own enable bit. An abort bit stops a transfer that is in progress. A block-level soft reset returns every register to zero.

Top module: `dma_channel`

## Requirements
- R1: After reset, all eight registers read zero, `bus_req` is low and `irq` is low. The register indices are: 0 control, 1 channel activate, 2 memory start, 3 memory end, 4 device address, 5 interrupt enable, 6 status, 7 block control.
- R2: The control field at bits [22:20] sets the unit size. The values 2 and 4 give 2- and 4-byte units, and any other value gives 1 byte. Every unit is one read followed by one write of the word that was read. `bus_size` shows the unit bytes. Request, address and write flag stay stable until `bus_ack`.
- R3: When a unit's write completes, memory start advances by the unit size. If control bit 2 is set, the memory address used is the current start value; otherwise it is the value last written to start. If control bit 3 is set, the device address register also advances by the unit size.
- R4: When start equals end while the channel is running, status bit 0 (done) sets, run and go clear, and no bus access is made. This includes a zero-length window at go time.
- R5: Control bit 1 set moves data from memory to the device. Control bit 1 clear moves data from the device to memory.
- R6: With control bit 4 clear, a unit begins only while `fc_req` is high and run (control bit 0) is set. `fc_ack` pulses once per unit, in the cycle that unit's write is acknowledged.
- R7: With control bit 4 set, the software go bit (control bit 5) runs the transfer and `fc_req` is ignored.
- R8: If `fc_req` drops while a unit is outstanding in flow-controlled mode, status bit 1 sets, run clears and memory start is not advanced.
- R9: An acknowledge that arrives together with `bus_err` sets status bit 2, clears run and go, and leaves memory start unchanged.
- R10: Writing control with bit 6 set withdraws any bus request and clears run and go. No status bit is set.
- R11: While run or go is set, writes to start, end and device address are ignored. Control writes can then only clear run, clear go or abort.
- R12: Status bits clear when a 1 is written to them (write-one-to-clear). `irq` is the OR of the status bits ANDed with the enable bits [2:0] of register 5.
- R13: Writing 1 to bit 0 of register 7 resets all channel state, including the block activate bit 1 of that register, and bit 0 clears itself. Units move only while register 1 bit 0 and register 7 bit 1 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_idx | input | 3 | Register index for writes |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_idx | input | 3 | Register index for reads |
| reg_rd_data | output | 32 | Register read data (combinational) |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | AW | Access address |
| bus_size | output | 3 | Unit size in bytes |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid with acknowledge |
| bus_ack | input | 1 | Access acknowledge |
| bus_err | input | 1 | Access error, valid with acknowledge |
| fc_req | input | 1 | Peripheral flow-control request |
| fc_ack | output | 1 | Per-unit flow-control acknowledge |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps unit sizes, both directions, the increment options and both pacing modes, with random wait states. It compares every write address and data word against a sequence derived from a snapshot of its memory model. A design that advanced start on a faulted access, or that kept moving data after a flow-control drop, would show a moved start register or extra writes. Directed cases cover the zero-length window, reserved size codes, and programming attempts while busy that must leave the registers unchanged. They also cover aborts that must withdraw the request without flagging status, and a soft reset that must also clear the block activate bit.

// File: rtl/dma_ch_pkg.sv
package dma_ch_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_READ, SEQ_WRITE} seq_state_e;

  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_ACT   = 3'd1;
  localparam logic [2:0] RA_START = 3'd2;
  localparam logic [2:0] RA_END   = 3'd3;
  localparam logic [2:0] RA_DEV   = 3'd4;
  localparam logic [2:0] RA_IEN   = 3'd5;
  localparam logic [2:0] RA_STS   = 3'd6;
  localparam logic [2:0] RA_BLK   = 3'd7;

  localparam int CB_RUN    = 0;
  localparam int CB_TODEV  = 1;
  localparam int CB_INCMEM = 2;
  localparam int CB_INCDEV = 3;
  localparam int CB_NOHW   = 4;
  localparam int CB_SWGO   = 5;
  localparam int CB_ABORT  = 6;
  localparam int CB_SZ_LO  = 20;

  function automatic logic [2:0] unit_of(input logic [2:0] f);
    return (f == 3'd2 || f == 3'd4) ? f : 3'd1;
  endfunction
endpackage

// File: rtl/dma_ch_regs.sv
module dma_ch_regs
  import dma_ch_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_idx,
  input  logic [31:0]   wr_data,
  input  logic [2:0]    rd_idx,
  output logic [31:0]   rd_data,
  input  logic          adv,
  input  logic          set_done,
  input  logic          set_fce,
  input  logic          set_bue,
  input  logic          halt,
  output logic          abort_o,
  output logic          engaged_o,
  output logic          to_dev_o,
  output logic          nohw_o,
  output logic [2:0]    unit_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [AW-1:0] dev_addr_o,
  output logic          at_end_o,
  output logic          irq_o
);
  logic run_q, run_d, swgo_q, swgo_d, todev_q, todev_d;
  logic incm_q, incm_d, incd_q, incd_d, nohw_q, nohw_d;
  logic act_q, act_d, bact_q, bact_d, srst_q, srst_d;
  logic [2:0] sz_q, sz_d, ien_q, ien_d, sts_q, sts_d;
  logic [AW-1:0] start_q, start_d, base_q, base_d, end_q, end_d, dev_q, dev_d;
  logic busy;
  logic [2:0] unit;

  assign busy    = run_q | swgo_q;
  assign unit    = unit_of(sz_q);
  assign abort_o = wr_en && (wr_idx == RA_CTRL) && wr_data[CB_ABORT];

  always_comb begin
    run_d = run_q; swgo_d = swgo_q; todev_d = todev_q; incm_d = incm_q;
    incd_d = incd_q; nohw_d = nohw_q; sz_d = sz_q; act_d = act_q;
    bact_d = bact_q; srst_d = 1'b0; ien_d = ien_q;
    start_d = start_q; base_d = base_q; end_d = end_q; dev_d = dev_q;
    if (wr_en) begin
      case (wr_idx)
        RA_CTRL: begin
          if (!busy) begin
            run_d   = wr_data[CB_RUN];
            swgo_d  = wr_data[CB_SWGO];
            todev_d = wr_data[CB_TODEV];
            incm_d  = wr_data[CB_INCMEM];
            incd_d  = wr_data[CB_INCDEV];
            nohw_d  = wr_data[CB_NOHW];
            sz_d    = wr_data[CB_SZ_LO +: 3];
          end else begin
            run_d  = run_q & wr_data[CB_RUN];
            swgo_d = swgo_q & wr_data[CB_SWGO];
          end
          if (wr_data[CB_ABORT]) begin
            run_d  = 1'b0;
            swgo_d = 1'b0;
          end
        end
        RA_ACT:   act_d = wr_data[0];
        RA_START: if (!busy) begin start_d = wr_data[AW-1:0]; base_d = wr_data[AW-1:0]; end
        RA_END:   if (!busy) end_d = wr_data[AW-1:0];
        RA_DEV:   if (!busy) dev_d = wr_data[AW-1:0];
        RA_IEN:   ien_d = wr_data[2:0];
        RA_BLK:   begin srst_d = wr_data[0]; bact_d = wr_data[1]; end
        default: ;
      endcase
    end
    if (adv) begin
      start_d = start_q + AW'(unit);
      if (incd_q) dev_d = dev_q + AW'(unit);
    end
    if (halt) begin
      run_d  = 1'b0;
      swgo_d = 1'b0;
    end
    sts_d = (sts_q & ~((wr_en && wr_idx == RA_STS) ? wr_data[2:0] : 3'b000))
          | {set_bue, set_fce, set_done};
    if (srst_q) begin
      run_d = 1'b0; swgo_d = 1'b0; todev_d = 1'b0; incm_d = 1'b0; incd_d = 1'b0;
      nohw_d = 1'b0; sz_d = '0; act_d = 1'b0; bact_d = 1'b0; srst_d = 1'b0;
      ien_d = '0; sts_d = '0; start_d = '0; base_d = '0; end_d = '0; dev_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; swgo_q <= 1'b0; todev_q <= 1'b0; incm_q <= 1'b0;
      incd_q <= 1'b0; nohw_q <= 1'b0; sz_q <= '0; act_q <= 1'b0;
      bact_q <= 1'b0; srst_q <= 1'b0; ien_q <= '0; sts_q <= '0;
      start_q <= '0; base_q <= '0; end_q <= '0; dev_q <= '0;
    end else begin
      run_q <= run_d; swgo_q <= swgo_d; todev_q <= todev_d; incm_q <= incm_d;
      incd_q <= incd_d; nohw_q <= nohw_d; sz_q <= sz_d; act_q <= act_d;
      bact_q <= bact_d; srst_q <= srst_d; ien_q <= ien_d; sts_q <= sts_d;
      start_q <= start_d; base_q <= base_d; end_q <= end_d; dev_q <= dev_d;
    end
  end

  assign engaged_o  = (nohw_q ? swgo_q : run_q) && act_q && bact_q && !srst_q;
  assign to_dev_o   = todev_q;
  assign nohw_o     = nohw_q;
  assign unit_o     = unit;
  assign mem_addr_o = incm_q ? start_q : base_q;
  assign dev_addr_o = dev_q;
  assign at_end_o   = (start_q == end_q);
  assign irq_o      = |(sts_q & ien_q);

  always_comb begin
    case (rd_idx)
      RA_CTRL:  rd_data = {9'b0, sz_q, 13'b0, 1'b0, swgo_q, nohw_q, incd_q, incm_q, todev_q, run_q};
      RA_ACT:   rd_data = {31'b0, act_q};
      RA_START: rd_data = 32'(start_q);
      RA_END:   rd_data = 32'(end_q);
      RA_DEV:   rd_data = 32'(dev_q);
      RA_IEN:   rd_data = {29'b0, ien_q};
      RA_STS:   rd_data = {29'b0, sts_q};
      default:  rd_data = {30'b0, bact_q, srst_q};
    endcase
  end

  // R11: start is locked while the channel is busy
  assert_start_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == RA_START && busy && !adv && !srst_q) |=> (start_q == $past(start_q)));
  // R9: a faulted access never moves start
  assert_buserr_no_adv_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set_bue |=> $stable(start_q));
  // R4: done only appears with the channel stopped
  assert_done_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[0]) |-> (!run_q && !swgo_q));
  // R12: written ones clear status
  assert_sts_w1c_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == RA_STS && !set_done && !set_fce && !set_bue && !srst_q)
      |=> ((sts_q & $past(wr_data[2:0])) == 3'b000));
  // R13: soft reset clears itself and the block activate bit
  assert_srst_self_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (!srst_q && !bact_q && !run_q));
endmodule

// File: rtl/dma_ch_seq.sv
module dma_ch_seq
  import dma_ch_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          engaged,
  input  logic          abort,
  input  logic          nohw,
  input  logic          to_dev,
  input  logic          fc_req,
  input  logic          at_end,
  input  logic [AW-1:0] mem_addr,
  input  logic [AW-1:0] dev_addr,
  input  logic [2:0]    unit,
  input  logic          bus_ack,
  input  logic          bus_err,
  input  logic [DW-1:0] bus_rdata,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [2:0]    bus_size,
  output logic [DW-1:0] bus_wdata,
  output logic          fc_ack,
  output logic          adv,
  output logic          set_done,
  output logic          set_fce,
  output logic          set_bue,
  output logic          halt
);
  seq_state_e st_q, st_d;
  logic [DW-1:0] dat_q, dat_d;
  logic live, fc_ok;

  assign live  = engaged && !abort;
  assign fc_ok = nohw || fc_req;

  always_comb begin
    st_d = st_q; dat_d = dat_q;
    adv = 1'b0; fc_ack = 1'b0; set_done = 1'b0; set_fce = 1'b0; set_bue = 1'b0; halt = 1'b0;
    case (st_q)
      SEQ_IDLE: begin
        if (live) begin
          if (at_end) begin
            set_done = 1'b1;
            halt     = 1'b1;
          end else if (fc_ok) begin
            st_d = SEQ_READ;
          end
        end
      end
      SEQ_READ, SEQ_WRITE: begin
        if (!live) begin
          st_d = SEQ_IDLE;
        end else if (!fc_ok) begin
          set_fce = 1'b1;
          halt    = 1'b1;
          st_d    = SEQ_IDLE;
        end else if (bus_ack) begin
          if (bus_err) begin
            set_bue = 1'b1;
            halt    = 1'b1;
            st_d    = SEQ_IDLE;
          end else if (st_q == SEQ_READ) begin
            dat_d = bus_rdata;
            st_d  = SEQ_WRITE;
          end else begin
            adv    = 1'b1;
            fc_ack = !nohw;
            st_d   = SEQ_IDLE;
          end
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      dat_q <= '0;
    end else begin
      st_q  <= st_d;
      dat_q <= dat_d;
    end
  end

  assign bus_req   = (st_q != SEQ_IDLE);
  assign bus_we    = (st_q == SEQ_WRITE);
  assign bus_addr  = ((st_q == SEQ_WRITE) != to_dev) ? mem_addr : dev_addr;
  assign bus_size  = unit;
  assign bus_wdata = dat_q;

  // R2: an unanswered request holds its address and kind
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack && live && fc_ok) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));
  // R6: the flow-control acknowledge closes the unit
  assert_fcack_ends_unit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fc_ack |=> !bus_req);
  // R10: abort withdraws the request
  assert_abort_drops_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !bus_req);
endmodule

// File: rtl/dma_channel.sv
module dma_channel
  import dma_ch_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr_en,
  input  logic [2:0]    reg_wr_idx,
  input  logic [31:0]   reg_wr_data,
  input  logic [2:0]    reg_rd_idx,
  output logic [31:0]   reg_rd_data,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [2:0]    bus_size,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ack,
  input  logic          bus_err,
  input  logic          fc_req,
  output logic          fc_ack,
  output logic          irq
);
  logic adv, set_done, set_fce, set_bue, halt;
  logic abort, engaged, to_dev, nohw, at_end;
  logic [2:0] unit;
  logic [AW-1:0] mem_addr, dev_addr;

  dma_ch_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en), .wr_idx(reg_wr_idx), .wr_data(reg_wr_data),
    .rd_idx(reg_rd_idx), .rd_data(reg_rd_data),
    .adv(adv), .set_done(set_done), .set_fce(set_fce), .set_bue(set_bue), .halt(halt),
    .abort_o(abort), .engaged_o(engaged), .to_dev_o(to_dev), .nohw_o(nohw),
    .unit_o(unit), .mem_addr_o(mem_addr), .dev_addr_o(dev_addr),
    .at_end_o(at_end), .irq_o(irq)
  );

  dma_ch_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .engaged(engaged), .abort(abort), .nohw(nohw), .to_dev(to_dev),
    .fc_req(fc_req), .at_end(at_end), .mem_addr(mem_addr), .dev_addr(dev_addr),
    .unit(unit), .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .fc_ack(fc_ack), .adv(adv), .set_done(set_done),
    .set_fce(set_fce), .set_bue(set_bue), .halt(halt)
  );
endmodule

// File: tb/dma_channel_tb.sv
module dma_channel_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic reg_wr_en;
  logic [2:0] reg_wr_idx, reg_rd_idx;
  logic [31:0] reg_wr_data, reg_rd_data;
  logic bus_req, bus_we, bus_ack, bus_err, fc_req, fc_ack, irq;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [2:0] bus_size;

  always #2 clk = ~clk;

  dma_channel u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx),
    .reg_wr_data(reg_wr_data), .reg_rd_idx(reg_rd_idx), .reg_rd_data(reg_rd_data),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err),
    .fc_req(fc_req), .fc_ack(fc_ack), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem [0:255];
  logic [31:0] wlog_a [0:63];
  logic [31:0] wlog_d [0:63];
  int wcnt = 0, acc_cnt = 0, fc_cnt = 0, size_bad = 0;
  int stall = 0, err_at = -1;
  logic [2:0] exp_unit = 3'd1;
  logic ack_q = 1'b0, req_q = 1'b0, we_q = 1'b0, err_q = 1'b0;
  logic [31:0] a_q = '0, d_q = '0;

  localparam logic [31:0] MEMB = 32'h2000_0000;
  localparam logic [31:0] DEVB = 32'h4000_0080;

  function automatic logic [31:0] init_val(input int a);
    logic [7:0] b = 8'(a);
    return {8'h5A, b, ~b, b ^ 8'h3C};
  endfunction

  function automatic logic [2:0] exp_unit_of(input logic [2:0] f);
    return (f == 3'd2 || f == 3'd4) ? f : 3'd1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bus slave and peripheral observer
  initial begin
    bus_ack = 1'b0; bus_err = 1'b0; bus_rdata = '0;
    forever begin
      @(negedge clk);
      if (ack_q && req_q) begin
        acc_cnt++;
        if (we_q && !err_q) begin
          if (wcnt < 64) begin wlog_a[wcnt] = a_q; wlog_d[wcnt] = d_q; end
          wcnt++;
          mem[a_q[7:0]] = d_q;
        end
      end
      if (bus_req && bus_size != exp_unit) size_bad++;
      bus_ack   = bus_req && (stall == 0) && ($urandom % 4 != 0);
      bus_err   = bus_ack && (acc_cnt == err_at);
      bus_rdata = mem[bus_addr[7:0]];
      ack_q = bus_ack; err_q = bus_err; req_q = bus_req; we_q = bus_we;
      a_q = bus_addr; d_q = bus_wdata;
      #1;
      if (fc_ack) fc_cnt++;
    end
  end

  task automatic wr(input logic [2:0] idx, input logic [31:0] data);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_idx = idx; reg_wr_data = data;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [31:0] val);
    @(negedge clk);
    reg_rd_idx = idx;
    #1 val = reg_rd_data;
  endtask

  task automatic wait_stop(output logic [31:0] sts);
    sts = '0;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd6, sts);
      if (sts != 0) break;
    end
  endtask

  function automatic logic [31:0] ctrl_word(input logic [2:0] sz, input bit todev,
      input bit incm, input bit incd, input bit nohw);
    return (32'(sz) << 20) | (32'(incd) << 3) | (32'(incm) << 2) | (32'(todev) << 1)
         | (32'(nohw) << 4) | (nohw ? 32'h20 : 32'h1);
  endfunction

  task automatic run_xfer(input logic [31:0] s, input int n, input logic [2:0] sz,
      input logic [31:0] d, input bit todev, input bit incm, input bit incd, input bit nohw);
    logic [31:0] ea [0:7];
    logic [31:0] ed [0:7];
    logic [31:0] v, sts;
    int u;
    exp_unit = exp_unit_of(sz);
    u = int'(exp_unit);
    for (int i = 0; i < n; i++) begin
      logic [31:0] m, dv, src;
      m  = incm ? s + 32'(i * u) : s;
      dv = incd ? d + 32'(i * u) : d;
      src = todev ? m : dv;
      ea[i] = todev ? dv : m;
      ed[i] = mem[src[7:0]];
    end
    fc_req = nohw ? 1'b0 : 1'b1;
    wr(3'd2, s); wr(3'd3, s + 32'(n * u)); wr(3'd4, d); wr(3'd6, 32'h7);
    wcnt = 0; fc_cnt = 0; size_bad = 0;
    wr(3'd0, ctrl_word(sz, todev, incm, incd, nohw));
    wait_stop(sts);
    chk(sts == 32'h1, "R4 done status", sts, 32'h1);
    chk(wcnt == n, "R2 write count", 32'(wcnt), 32'(n));
    chk(size_bad == 0, "R2 bus_size", 32'(size_bad), 0);
    for (int i = 0; i < n && i < wcnt; i++) begin
      chk(wlog_a[i] == ea[i], todev ? "R5 write addr to device" : "R3 write addr to memory", wlog_a[i], ea[i]);
      chk(wlog_d[i] == ed[i], "R5 write data", wlog_d[i], ed[i]);
    end
    rd(3'd2, v);
    chk(v == s + 32'(n * u), "R3 start advanced", v, s + 32'(n * u));
    rd(3'd4, v);
    chk(v == (incd ? d + 32'(n * u) : d), "R3 device address", v, incd ? d + 32'(n * u) : d);
    chk(fc_cnt == (nohw ? 0 : n), nohw ? "R7 no fc_ack in go mode" : "R6 fc_ack count",
        32'(fc_cnt), nohw ? 0 : 32'(n));
    rd(3'd0, v);
    chk(v[5] == 1'b0 && v[0] == 1'b0, "R4 run and go cleared", v, v & ~32'h21);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v, sts, a0;
    int base_acc;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) mem[i] = init_val(i);
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_wr_idx = '0; reg_wr_data = '0; reg_rd_idx = '0;
    fc_req = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), v);
      chk(v == 0, "R1 register reset value", v, 0);
    end
    chk(bus_req == 1'b0 && irq == 1'b0, "R1 bus_req and irq low", {30'b0, bus_req, irq}, 0);

    // R13 gating: block activate still clear
    wr(3'd1, 32'h1);
    wr(3'd2, MEMB + 32'h10); wr(3'd3, MEMB + 32'h18); wr(3'd4, DEVB);
    base_acc = acc_cnt;
    wr(3'd0, ctrl_word(3'd4, 1'b1, 1'b1, 1'b0, 1'b0));
    repeat (10) @(negedge clk);
    rd(3'd6, sts);
    chk(acc_cnt == base_acc && sts == 0, "R13 no movement without block activate", sts, 0);
    wr(3'd0, 32'h40);
    wr(3'd7, 32'h2);

    // directed transfers
    run_xfer(MEMB + 32'h10, 4, 3'd4, DEVB, 1'b1, 1'b1, 1'b0, 1'b0);
    run_xfer(MEMB + 32'h20, 3, 3'd2, DEVB + 32'h10, 1'b0, 1'b1, 1'b1, 1'b1);
    run_xfer(MEMB + 32'h30, 5, 3'd3, DEVB, 1'b1, 1'b0, 1'b0, 1'b0); // R2 reserved size acts as 1 byte
    run_xfer(MEMB + 32'h08, 2, 3'd0, DEVB + 32'h20, 1'b0, 1'b0, 1'b1, 1'b0);

    // R4 zero-length window
    wr(3'd6, 32'h7);
    wr(3'd2, MEMB + 32'h40); wr(3'd3, MEMB + 32'h40);
    base_acc = acc_cnt;
    wr(3'd0, ctrl_word(3'd4, 1'b1, 1'b1, 1'b0, 1'b0));
    repeat (3) @(negedge clk);
    rd(3'd6, sts);
    chk(sts == 32'h1, "R4 zero-length done", sts, 32'h1);
    chk(acc_cnt == base_acc, "R4 zero-length no bus access", 32'(acc_cnt - base_acc), 0);

    // R11 lock while busy, then R10 abort
    wr(3'd6, 32'h7);
    stall = 1; fc_req = 1'b1; exp_unit = 3'd4;
    wr(3'd2, MEMB + 32'h10); wr(3'd3, MEMB + 32'h20);
    wr(3'd0, ctrl_word(3'd4, 1'b1, 1'b1, 1'b0, 1'b0));
    repeat (3) @(negedge clk);
    wr(3'd2, MEMB + 32'h44);
    rd(3'd2, v);
    chk(v == MEMB + 32'h10, "R11 start write ignored while busy", v, MEMB + 32'h10);
    wr(3'd0, (32'd2 << 20) | 32'h1);
    rd(3'd0, v);
    chk(v[22:20] == 3'd4, "R11 size write ignored while busy", 32'(v[22:20]), 4);
    chk(bus_req == 1'b1, "R11 request still pending", 32'(bus_req), 1);
    wr(3'd0, 32'h41);
    @(negedge clk);
    chk(bus_req == 1'b0, "R10 abort drops request", 32'(bus_req), 0);
    rd(3'd0, v);
    chk(v[0] == 1'b0, "R10 abort clears run", v, v & ~32'h1);
    rd(3'd6, sts);
    chk(sts == 0, "R10 abort sets no status", sts, 0);

    // R8 flow-control error
    wr(3'd0, ctrl_word(3'd4, 1'b1, 1'b1, 1'b0, 1'b0));
    repeat (3) @(negedge clk);
    fc_req = 1'b0;
    repeat (3) @(negedge clk);
    rd(3'd6, sts);
    chk(sts == 32'h2, "R8 flow-control error status", sts, 32'h2);
    rd(3'd2, v);
    chk(v == MEMB + 32'h10, "R8 start unchanged", v, MEMB + 32'h10);
    rd(3'd0, v);
    chk(v[0] == 1'b0, "R8 run cleared", v, v & ~32'h1);
    stall = 0; fc_req = 1'b1;

    // R9 bus error on the first access
    wr(3'd6, 32'h7);
    wcnt = 0;
    err_at = acc_cnt;
    wr(3'd0, ctrl_word(3'd4, 1'b1, 1'b1, 1'b0, 1'b0));
    wait_stop(sts);
    chk(sts == 32'h4, "R9 bus error status", sts, 32'h4);
    rd(3'd2, a0);
    chk(a0 == MEMB + 32'h10, "R9 start unchanged", a0, MEMB + 32'h10);
    chk(wcnt == 0, "R9 no write after error", 32'(wcnt), 0);
    err_at = -1;

    // R12 interrupt and write-one-to-clear
    @(negedge clk);
    chk(irq == 1'b0, "R12 irq masked", 32'(irq), 0);
    wr(3'd5, 32'h4);
    @(negedge clk);
    chk(irq == 1'b1, "R12 irq from enabled bus error", 32'(irq), 1);
    wr(3'd6, 32'h3);
    rd(3'd6, sts);
    chk(sts == 32'h4, "R12 writing other bits keeps status", sts, 32'h4);
    wr(3'd6, 32'h4);
    rd(3'd6, sts);
    chk(sts == 0 && irq == 1'b0, "R12 status cleared and irq low", sts, 0);

    // R13 soft reset
    wr(3'd7, 32'h3);
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), v);
      chk(v == 0, "R13 soft reset clears register", v, 0);
    end
    wr(3'd7, 32'h2); wr(3'd1, 32'h1);

    // random transfers
    for (int k = 0; k < 24; k++) begin
      logic [2:0] szr;
      int pick, n;
      pick = int'($urandom % 3);
      szr = (pick == 0) ? 3'd1 : (pick == 1) ? 3'd2 : 3'd4;
      n = 1 + int'($urandom % 6);
      run_xfer(MEMB + 32'($urandom % 64), n, szr, DEVB + 32'($urandom % 64),
               1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule